// File: doc/BRIEF.md
# CRC4 Multiframe Search Counter

This block keeps track of how long an E1 receive framer has been hunting for CRC4 multiframe alignment. Each time an 8 ms CRC4 search window runs out without alignment, a timeout strobe arrives and a 6-bit counter advances. The counter returns to zero when alignment is found or when CRC4 mode is switched off. It wraps rather than saturating.

The count is packed with three live search-activity flags from the synchronizer into one 8-bit status byte. One counter bit is left out of that byte. A sticky abandon flag marks the point, roughly 400 ms of fruitless search, at which the framer should give up on CRC4. Software reads the byte through a strobe-sampled read register, so the value it gets cannot change in the middle of an access.

Top module: `crc4_hunt_meter`

## Requirements
- R1: After reset the counter is zero, `abandon` is 0 and `rd_data` is 0x00.
- R2: With CRC4 mode enabled and no sync strobe, each cycle with `tmo_stb` high adds one to the counter. The new value is visible one cycle later.
- R3: A cycle with `sync_stb` high sets the counter to zero on the next edge.
- R4: While `crc4_mode_en` is 0, the counter is zero and stays zero, and timeout strobes have no effect on it.
- R5: When `tmo_stb` and `sync_stb` are high in the same cycle, the counter is cleared, not advanced.
- R6: A timeout taken at count 63 brings the counter to 0. There is no saturation.
- R7: In `status`, the counter bits 5, 4, 3, 2 and 0 sit at bits 7, 6, 5, 4 and 3. Counter bit 1 is not present. The FAS search flag is at bit 2, the CAS search flag at bit 1 and the CRC4 search flag at bit 0. The three flags follow their inputs combinationally.
- R8: `abandon` rises in the cycle after the ABANDON_LIMIT-th timeout since the last clear, and not before it.
- R9: Once set, `abandon` stays high through counter wraparound until a sync strobe or a mode disable clears it.
- R10: On a cycle with `rd_stb` high, `rd_data` takes the value `status` has in that cycle. Otherwise `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_stb | input | 1 | CRC4 search window expired without alignment |
| sync_stb | input | 1 | CRC4-level alignment obtained |
| crc4_mode_en | input | 1 | CRC4 mode enable; 0 clears and holds the counter |
| fas_hunt | input | 1 | Synchronizer searching for FAS alignment |
| cas_hunt | input | 1 | Synchronizer searching for CAS multiframe alignment |
| crc4_hunt | input | 1 | Synchronizer searching for CRC4 multiframe alignment |
| rd_stb | input | 1 | Read strobe; samples the status byte |
| status | output | 8 | Live packed status byte |
| rd_data | output | 8 | Status byte captured on the last read strobe |
| abandon | output | 1 | Sticky: search has run past the abandon limit |

## Verification
The bench builds the block with the default ABANDON_LIMIT of 50. It drives the counter one timeout at a time, stepping both from 49 to 50 and from 63 through the wrap back to 0. This shows the exact cycle the abandon flag rises and that it survives the wrap. With the count set to 2 and then 3, the bench shows that counter bit 1 never reaches the byte while bit 0 lands at position 3.

// File: rtl/crc4_hunt_meter.sv
module crc4_hunt_meter #(
  parameter int unsigned ABANDON_LIMIT = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmo_stb,
  input  logic       sync_stb,
  input  logic       crc4_mode_en,
  input  logic       fas_hunt,
  input  logic       cas_hunt,
  input  logic       crc4_hunt,
  input  logic       rd_stb,
  output logic [7:0] status,
  output logic [7:0] rd_data,
  output logic       abandon
);

  localparam int unsigned CW = 6;
  localparam logic [CW-1:0] LIM_M1 = CW'(ABANDON_LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          clr;

  assign clr = sync_stb | ~crc4_mode_en;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tmo_stb) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          abandon <= 1'b0;
    else if (clr)                        abandon <= 1'b0;
    else if (tmo_stb && cnt_q >= LIM_M1) abandon <= 1'b1;
  end

  assign status = {cnt_q[5:2], cnt_q[0], fas_hunt, cas_hunt, crc4_hunt};

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= 8'h00;
    else if (rd_stb) rd_data <= status;
  end

endmodule

// File: rtl/crc4_hunt_meter_chk.sv
module crc4_hunt_meter_chk #(
  parameter int unsigned ABANDON_LIMIT = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tmo_stb,
  input logic       sync_stb,
  input logic       crc4_mode_en,
  input logic       rd_stb,
  input logic [7:0] status,
  input logic [7:0] rd_data,
  input logic       abandon,
  input logic [5:0] cnt
);

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_stb && !sync_stb && crc4_mode_en && cnt != 6'd63) |=> cnt == 6'($past(cnt) + 6'd1));

  // R3
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_stb |=> cnt == 6'd0);

  // R4
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crc4_mode_en |=> (cnt == 6'd0 && !abandon));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_stb && !sync_stb && crc4_mode_en && cnt == 6'd63) |=> cnt == 6'd0);

  // R8
  abandon_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_stb && !sync_stb && crc4_mode_en && cnt == 6'(ABANDON_LIMIT - 1)) |=> abandon);

  // R9
  abandon_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abandon && !sync_stb && crc4_mode_en) |=> abandon);

  // R10
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_data == $past(status));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

endmodule

bind crc4_hunt_meter crc4_hunt_meter_chk #(.ABANDON_LIMIT(ABANDON_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_stb(tmo_stb), .sync_stb(sync_stb),
  .crc4_mode_en(crc4_mode_en), .rd_stb(rd_stb), .status(status),
  .rd_data(rd_data), .abandon(abandon), .cnt(cnt_q)
);

// File: tb/crc4_hunt_meter_bench.sv
module crc4_hunt_meter_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmo_stb = 1'b0, sync_stb = 1'b0, crc4_mode_en = 1'b1;
  logic fas_hunt = 1'b0, cas_hunt = 1'b0, crc4_hunt = 1'b0, rd_stb = 1'b0;
  logic [7:0] status, rd_data;
  logic abandon;

  int tests = 0;
  int fails = 0;
  int ec = 0;

  always #2 clk = ~clk;

  crc4_hunt_meter u_crc4_hunt_meter (
    .clk(clk), .rst_n(rst_n), .tmo_stb(tmo_stb), .sync_stb(sync_stb),
    .crc4_mode_en(crc4_mode_en), .fas_hunt(fas_hunt), .cas_hunt(cas_hunt),
    .crc4_hunt(crc4_hunt), .rd_stb(rd_stb), .status(status),
    .rd_data(rd_data), .abandon(abandon)
  );

  function automatic logic [4:0] vis(int c);
    logic [5:0] b;
    b = 6'(c);
    return {b[5:2], b[0]};
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic timeouts(int n);
    for (int i = 0; i < n; i++) begin
      tmo_stb = 1'b1; step(); tmo_stb = 1'b0;
      ec = (ec + 1) % 64;
    end
  endtask

  task automatic do_sync();
    sync_stb = 1'b1; step(); sync_stb = 1'b0;
    ec = 0;
  endtask

  task automatic t_reset();
    check("R1 count", int'(status[7:3]), 0);
    check("R1 abandon", int'(abandon), 0);
    check("R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 5; i++) begin
      timeouts(1);
      check("R2 count", int'(status[7:3]), int'(vis(ec)));
    end
    step();
    check("R2 idle hold", int'(status[7:3]), int'(vis(ec)));
  endtask

  task automatic t_layout();
    do_sync();
    timeouts(2);
    check("R7 bit1 hidden", int'(status[7:3]), 0);
    timeouts(1);
    check("R7 bit0 pos3", int'(status[7:3]), 5'b00001);
    timeouts(9);
    check("R7 count12", int'(status[7:3]), 5'b00110);
    fas_hunt = 1'b1; cas_hunt = 1'b0; crc4_hunt = 1'b1; #0.5;
    check("R7 flags 101", int'(status[2:0]), 3'b101);
    fas_hunt = 1'b0; cas_hunt = 1'b1; crc4_hunt = 1'b0; #0.5;
    check("R7 flags 010", int'(status[2:0]), 3'b010);
    cas_hunt = 1'b0;
  endtask

  task automatic t_sync();
    timeouts(3);
    do_sync();
    check("R3 cleared", int'(status[7:3]), 0);
  endtask

  task automatic t_collide();
    timeouts(4);
    tmo_stb = 1'b1; sync_stb = 1'b1; step();
    tmo_stb = 1'b0; sync_stb = 1'b0; ec = 0;
    check("R5 clear wins", int'(status[7:3]), 0);
  endtask

  task automatic t_mode();
    timeouts(7);
    crc4_mode_en = 1'b0; step(); ec = 0;
    check("R4 cleared", int'(status[7:3]), 0);
    tmo_stb = 1'b1; step(); step(); tmo_stb = 1'b0;
    check("R4 tmo ignored", int'(status[7:3]), 0);
    crc4_mode_en = 1'b1; step();
    check("R4 still zero", int'(status[7:3]), 0);
  endtask

  task automatic t_abandon_wrap();
    do_sync();
    timeouts(49);
    check("R8 not yet", int'(abandon), 0);
    timeouts(1);
    check("R8 set", int'(abandon), 1);
    check("R8 count50", int'(status[7:3]), int'(vis(50)));
    timeouts(13);
    check("R6 at63", int'(status[7:3]), int'(vis(63)));
    timeouts(1);
    check("R6 wrap", int'(status[7:3]), 0);
    check("R9 sticky", int'(abandon), 1);
    timeouts(2);
    check("R9 still", int'(abandon), 1);
    do_sync();
    check("R9 cleared", int'(abandon), 0);
  endtask

  task automatic t_read();
    logic [7:0] snap;
    timeouts(9);
    fas_hunt = 1'b1; crc4_hunt = 1'b1; #0.5;
    snap = status;
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    check("R10 capture", int'(rd_data), int'(snap));
    fas_hunt = 1'b0; crc4_hunt = 1'b0;
    timeouts(3);
    check("R10 hold", int'(rd_data), int'(snap));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1; step();
    t_count();
    t_layout();
    t_sync();
    t_collide();
    t_mode();
    t_abandon_wrap();
    t_read();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule